// File: doc/BRIEF.md
# External Device Access Gate

This block sits between the core's external-control load-word and store-word operations and a device that has its own address space. It keeps a 32-bit access control word that holds an enable flag and a resource identifier. Only a hypervisor-privileged context may read or write that word. Each request carries a direction, a translated byte address, store data and the current data-relocation mode bit. The block checks every request against the control word before anything reaches the device.

A permitted request becomes a single-word transaction on a valid/ready device port, tagged with the stored resource identifier. One transaction is outstanding at a time. A read finishes when the device returns a response pulse with data; a write finishes when the device accepts it. A refused request never reaches the device. It gets a one-cycle data-storage fault, which comes with a syndrome word. Requests are held back while an address-translation invalidation is pending, so the device cannot use an address whose translation is being torn down.

Top module: `eag_top`

## Requirements
- R1: After synchronous reset the control word reads 0 (enable clear), `reqReady` is 1 and `devValid`, `doneValid`, `dsiFault`, `alignFault` and `cfgPrivErr` are 0.
- R2: In the control word, the enable flag is bit 31 and the resource identifier is bits RID_W-1:0, with RID_W at most 6. All other bits read as 0 and ignore writes. This includes identifier bits at or above RID_W. `devRid` carries the identifier zero-extended to 6 bits.
- R3: A control write with `cfgHyp`=0 leaves the word unchanged and raises `cfgPrivErr` for one cycle, in the cycle after the write. A read with `cfgHyp`=0 returns 0 on `cfgRdData`.
- R4: A request accepted while the enable flag is 0 produces `dsiFault`=1 for exactly the cycle after acceptance. In that cycle `dsiSyndrome` is 32'h0010_0000 (only bit 20 set). No device transaction is started; at all other times `dsiSyndrome` is 0.
- R5: A request accepted with `reqDr`=0 produces the same fault as R4, even when the enable flag is 1.
- R6: A permitted request whose address has a nonzero bit 1 or bit 0 produces `alignFault`=1 for the cycle after acceptance and starts no device transaction. When both faults apply, `dsiFault` takes priority.
- R7: A permitted store drives `devValid`=1 from the cycle after acceptance, with `devWrite`=1, the identifier, the address and the data. These stay stable until `devReady` is 1. `doneValid` pulses in the cycle after that handshake.
- R8: A permitted load drives `devValid` with `devWrite`=0. After the handshake, a `devRspValid` pulse yields `doneValid`=1 with `doneData` equal to the returned data in the following cycle.
- R9: `reqReady` is 0 from the cycle after an accepted permitted request until its `doneValid` cycle. At most one device transaction is outstanding.
- R10: While `invalPending` is 1, `reqReady` is 0 and no request is accepted. A waiting request is accepted once `invalPending` returns to 0.
- R11: A privileged control write takes effect in the next cycle. A request accepted in the same cycle as the write is checked against the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 32 | Control word write data |
| cfgHyp | input | 1 | Access is hypervisor-privileged |
| cfgRdData | output | 32 | Control word read data (0 when unprivileged) |
| cfgPrivErr | output | 1 | Unprivileged write was blocked |
| reqValid | input | 1 | External-control request present |
| reqReady | output | 1 | Request accepted this cycle when valid |
| reqStore | input | 1 | 1 = store word, 0 = load word |
| reqAddr | input | 32 | Translated byte address |
| reqWdata | input | 32 | Store data |
| reqDr | input | 1 | Data relocation mode bit at issue |
| invalPending | input | 1 | Translation invalidation in progress |
| doneValid | output | 1 | Request completed |
| doneData | output | 32 | Load result |
| dsiFault | output | 1 | Data-storage fault pulse |
| dsiSyndrome | output | 32 | Syndrome word for the fault |
| alignFault | output | 1 | Misaligned address pulse |
| devValid | output | 1 | Device transaction valid |
| devReady | input | 1 | Device accepts transaction |
| devWrite | output | 1 | Device transaction is a write |
| devRid | output | 6 | Resource identifier tag |
| devAddr | output | 32 | Word-aligned device address |
| devWdata | output | 32 | Device write data |
| devRspValid | input | 1 | Device read response valid |
| devRspData | input | 32 | Device read response data |

## Verification
The bench builds the block with RID_W=4, narrower than the 6-bit field. This setting makes identifier bits 5:4 behave as reserved, so a write of all ones has to read back as 32'h8000_000F and tag `devRid` with 4'hF. The narrow identifier also exercises the zero-extension path onto the 6-bit device tag. The remaining behaviours do not depend on the parameter and are covered as written: the same-cycle write-and-request ordering, device backpressure, and the stall under a pending invalidation.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int CFG_W      = 32;
  localparam int RID_PORT_W = 6;
  localparam int EN_BIT     = 31;
  localparam int SYND_BIT   = 20;
  localparam logic [31:0] DSI_SYND = 32'h1 << SYND_BIT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } eag_state_e;

  typedef struct packed {
    logic latchOp;
    logic latchRsp;
  } eag_strobe_t;
endpackage

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
#(
  parameter int RID_W = 6,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              cfgHyp,
  output logic [CFG_W-1:0]  cfgWord,
  output logic [CFG_W-1:0]  cfgRdData,
  output logic              cfgPrivErr,
  input  eag_strobe_t       strobe,
  input  logic              reqStore,
  input  logic [AW-1:0]     reqAddr,
  input  logic [DW-1:0]     reqWdata,
  input  logic              reqDr,
  output logic              permitOk,
  output logic              misaligned,
  output logic              opStore,
  output logic [RID_PORT_W-1:0] devRid,
  output logic [AW-1:0]     devAddr,
  output logic [DW-1:0]     devWdata,
  input  logic [DW-1:0]     devRspData,
  output logic [DW-1:0]     doneData
);
  localparam int PAD_W = CFG_W - 1 - RID_W;

  logic             cfgEn;
  logic [RID_W-1:0] cfgRid;
  logic [RID_W-1:0] opRid;
  logic             privErrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgEn    <= 1'b0;
      cfgRid   <= '0;
      privErrQ <= 1'b0;
    end else begin
      privErrQ <= cfgWrEn & ~cfgHyp;
      if (cfgWrEn && cfgHyp) begin
        cfgEn  <= cfgWrData[EN_BIT];
        cfgRid <= cfgWrData[RID_W-1:0];
      end
    end
  end

  assign cfgWord    = {cfgEn, {PAD_W{1'b0}}, cfgRid};
  assign cfgRdData  = cfgHyp ? cfgWord : '0;
  assign cfgPrivErr = privErrQ;

  assign permitOk   = cfgEn & reqDr;
  assign misaligned = |reqAddr[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      opStore  <= 1'b0;
      opRid    <= '0;
      devAddr  <= '0;
      devWdata <= '0;
      doneData <= '0;
    end else begin
      if (strobe.latchOp) begin
        opStore  <= reqStore;
        opRid    <= cfgRid;
        devAddr  <= reqAddr;
        devWdata <= reqWdata;
      end
      if (strobe.latchRsp) doneData <= devRspData;
    end
  end

  generate
    if (RID_W < RID_PORT_W) begin : g_ridPad
      assign devRid = {{(RID_PORT_W-RID_W){1'b0}}, opRid};
    end else begin : g_ridFull
      assign devRid = opRid;
    end
  endgenerate
endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        invalPending,
  input  logic        permitOk,
  input  logic        misaligned,
  input  logic        opStore,
  input  logic        devReady,
  input  logic        devRspValid,
  output logic        reqReady,
  output logic        devValid,
  output logic        doneValid,
  output logic        dsiFault,
  output logic        alignFault,
  output eag_strobe_t strobe
);
  eag_state_e state;
  logic accept;

  assign reqReady = (state == ST_IDLE) & ~invalPending;
  assign accept   = reqValid & reqReady;
  assign devValid = (state == ST_ISSUE);

  always_comb begin
    strobe.latchOp  = accept & permitOk & ~misaligned;
    strobe.latchRsp = (state == ST_WAIT) & devRspValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      doneValid  <= 1'b0;
      dsiFault   <= 1'b0;
      alignFault <= 1'b0;
    end else begin
      doneValid  <= 1'b0;
      dsiFault   <= 1'b0;
      alignFault <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (!permitOk)      dsiFault   <= 1'b1;
          else if (misaligned) alignFault <= 1'b1;
          else                state      <= ST_ISSUE;
        end
        ST_ISSUE: if (devReady) begin
          if (opStore) begin
            doneValid <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: if (devRspValid) begin
          doneValid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int RID_W = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  input  logic        cfgHyp,
  output logic [31:0] cfgRdData,
  output logic        cfgPrivErr,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqStore,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWdata,
  input  logic        reqDr,
  input  logic        invalPending,
  output logic        doneValid,
  output logic [31:0] doneData,
  output logic        dsiFault,
  output logic [31:0] dsiSyndrome,
  output logic        alignFault,
  output logic        devValid,
  input  logic        devReady,
  output logic        devWrite,
  output logic [5:0]  devRid,
  output logic [31:0] devAddr,
  output logic [31:0] devWdata,
  input  logic        devRspValid,
  input  logic [31:0] devRspData
);
  eag_strobe_t strobe;
  logic [31:0] cfgWord;
  logic permitOk, misaligned, opStore;

  eag_datapath #(.RID_W(RID_W), .AW(32), .DW(32)) u_dp (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgHyp(cfgHyp), .cfgWord(cfgWord), .cfgRdData(cfgRdData),
    .cfgPrivErr(cfgPrivErr), .strobe(strobe), .reqStore(reqStore),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqDr(reqDr),
    .permitOk(permitOk), .misaligned(misaligned), .opStore(opStore),
    .devRid(devRid), .devAddr(devAddr), .devWdata(devWdata),
    .devRspData(devRspData), .doneData(doneData)
  );

  eag_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .invalPending(invalPending),
    .permitOk(permitOk), .misaligned(misaligned), .opStore(opStore),
    .devReady(devReady), .devRspValid(devRspValid), .reqReady(reqReady),
    .devValid(devValid), .doneValid(doneValid), .dsiFault(dsiFault),
    .alignFault(alignFault), .strobe(strobe)
  );

  assign devWrite    = opStore;
  assign dsiSyndrome = dsiFault ? DSI_SYND : 32'h0;
endmodule

// File: rtl/eag_checker.sv
module eag_checker (
  input logic        clk,
  input logic        rst,
  input logic        reqValid,
  input logic        reqReady,
  input logic        invalPending,
  input logic        devValid,
  input logic        devReady,
  input logic [31:0] devAddr,
  input logic [31:0] devWdata,
  input logic        dsiFault,
  input logic [31:0] dsiSyndrome,
  input logic        alignFault,
  input logic        doneValid,
  input logic        cfgWrEn,
  input logic        cfgHyp,
  input logic [31:0] cfgWord
);
  // R10: no acceptance during a pending invalidation
  p_stall_inval_r10: assert property (@(posedge clk) disable iff (rst)
    invalPending |-> !reqReady);

  // R7: transaction fields held under backpressure
  p_hold_dev_r7: assert property (@(posedge clk) disable iff (rst)
    (devValid && !devReady) |=> (devValid && $stable(devAddr) && $stable(devWdata)));

  // R9: no new acceptance while a transaction is on the device port
  p_single_r9: assert property (@(posedge clk) disable iff (rst)
    devValid |-> !reqReady);

  // R4: syndrome word accompanies the fault
  p_synd_r4: assert property (@(posedge clk) disable iff (rst)
    dsiFault |-> (dsiSyndrome == 32'h0010_0000));

  // R4: disabled gate refuses the request
  p_refuse_r4: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && !cfgWord[31]) |=> (dsiFault && !devValid));

  // R6: faults never start the device
  p_fault_nodev_r6: assert property (@(posedge clk) disable iff (rst)
    (dsiFault || alignFault) |-> !devValid);

  // R3: unprivileged writes leave the word alone
  p_priv_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cfgWrEn && !cfgHyp) |=> (cfgWord == $past(cfgWord)));

  // R9: completion and fault pulses are exclusive
  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dsiFault, alignFault, doneValid}));
endmodule

bind eag_top eag_checker u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
  .invalPending(invalPending), .devValid(devValid), .devReady(devReady),
  .devAddr(devAddr), .devWdata(devWdata), .dsiFault(dsiFault),
  .dsiSyndrome(dsiSyndrome), .alignFault(alignFault), .doneValid(doneValid),
  .cfgWrEn(cfgWrEn), .cfgHyp(cfgHyp), .cfgWord(cfgWord)
);

// File: tb/eag_top_tb.sv
module eag_top_tb;
  logic clk = 1'b0;
  logic rst;
  logic cfgWrEn, cfgHyp, cfgPrivErr;
  logic [31:0] cfgWrData, cfgRdData;
  logic reqValid, reqReady, reqStore, reqDr, invalPending;
  logic [31:0] reqAddr, reqWdata;
  logic doneValid, dsiFault, alignFault;
  logic [31:0] doneData, dsiSyndrome;
  logic devValid, devReady, devWrite, devRspValid;
  logic [5:0] devRid;
  logic [31:0] devAddr, devWdata, devRspData;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  eag_top #(.RID_W(4)) u_dut (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgHyp(cfgHyp), .cfgRdData(cfgRdData), .cfgPrivErr(cfgPrivErr),
    .reqValid(reqValid), .reqReady(reqReady), .reqStore(reqStore),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqDr(reqDr),
    .invalPending(invalPending), .doneValid(doneValid), .doneData(doneData),
    .dsiFault(dsiFault), .dsiSyndrome(dsiSyndrome), .alignFault(alignFault),
    .devValid(devValid), .devReady(devReady), .devWrite(devWrite),
    .devRid(devRid), .devAddr(devAddr), .devWdata(devWdata),
    .devRspValid(devRspValid), .devRspData(devRspData)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [31:0] d, input logic hyp);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = d; cfgHyp = hyp;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgHyp = 1'b1;
  endtask

  // presents a request, returns at the negedge after the accepting edge
  task automatic putReq(input logic st, input logic [31:0] a, input logic [31:0] d, input logic dr);
    @(negedge clk);
    reqValid = 1'b1; reqStore = st; reqAddr = a; reqWdata = d; reqDr = dr;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic testReset();
    chk(cfgRdData == 32'h0, "R1 cfg", cfgRdData, 32'h0);
    chk(reqReady == 1'b1, "R1 ready", {31'b0, reqReady}, 32'h1);
    chk({devValid, doneValid, dsiFault, alignFault, cfgPrivErr} == 5'b0, "R1 outs",
        {27'b0, devValid, doneValid, dsiFault, alignFault, cfgPrivErr}, 32'h0);
  endtask

  task automatic testDisabled();
    putReq(1'b1, 32'h100, 32'hAA, 1'b1);
    chk(dsiFault == 1'b1, "R4 fault", {31'b0, dsiFault}, 32'h1);
    chk(dsiSyndrome == 32'h0010_0000, "R4 synd", dsiSyndrome, 32'h0010_0000);
    chk(devValid == 1'b0, "R4 nodev", {31'b0, devValid}, 32'h0);
    @(negedge clk);
    chk(dsiFault == 1'b0 && dsiSyndrome == 32'h0, "R4 pulse", dsiSyndrome, 32'h0);
  endtask

  task automatic testPriv();
    cfgWrite(32'h8000_0003, 1'b0);
    chk(cfgPrivErr == 1'b1, "R3 priverr", {31'b0, cfgPrivErr}, 32'h1);
    chk(cfgRdData == 32'h0, "R3 unchanged", cfgRdData, 32'h0);
    @(negedge clk);
    chk(cfgPrivErr == 1'b0, "R3 pulse", {31'b0, cfgPrivErr}, 32'h0);
  endtask

  task automatic testLayout();
    cfgWrite(32'hFFFF_FFFF, 1'b1);
    chk(cfgRdData == 32'h8000_000F, "R2 reserved", cfgRdData, 32'h8000_000F);
    cfgHyp = 1'b0; #1;
    chk(cfgRdData == 32'h0, "R3 read", cfgRdData, 32'h0);
    cfgHyp = 1'b1;
    cfgWrite(32'h8000_0035, 1'b1);
    chk(cfgRdData == 32'h8000_0005, "R2 rid", cfgRdData, 32'h8000_0005);
  endtask

  task automatic testStore(input int stallCycles);
    devReady = (stallCycles == 0);
    putReq(1'b1, 32'h0000_1230, 32'hCAFE_0001, 1'b1);
    chk(devValid && devWrite, "R7 issue", {30'b0, devValid, devWrite}, 32'h3);
    chk(devAddr == 32'h1230, "R7 addr", devAddr, 32'h1230);
    chk(devWdata == 32'hCAFE_0001, "R7 data", devWdata, 32'hCAFE_0001);
    chk(devRid == 6'd5, "R2 tag", {26'b0, devRid}, 32'd5);
    chk(reqReady == 1'b0, "R9 busy", {31'b0, reqReady}, 32'h0);
    for (int i = 0; i < stallCycles; i++) begin
      @(negedge clk);
      chk(devValid && devAddr == 32'h1230 && !doneValid, "R7 hold", devAddr, 32'h1230);
    end
    devReady = 1'b1;
    @(negedge clk);
    chk(doneValid == 1'b1 && devValid == 1'b0, "R7 done", {30'b0, doneValid, devValid}, 32'h2);
    @(negedge clk);
    chk(reqReady == 1'b1, "R9 idle", {31'b0, reqReady}, 32'h1);
  endtask

  task automatic testLoad();
    devReady = 1'b1;
    putReq(1'b0, 32'h0000_0040, 32'h0, 1'b1);
    chk(devValid && !devWrite, "R8 issue", {30'b0, devValid, devWrite}, 32'h2);
    @(negedge clk);
    chk(!devValid && !doneValid && !reqReady, "R9 wait", {31'b0, reqReady}, 32'h0);
    devRspValid = 1'b1; devRspData = 32'h1357_9BDF;
    @(negedge clk);
    devRspValid = 1'b0;
    chk(doneValid == 1'b1, "R8 done", {31'b0, doneValid}, 32'h1);
    chk(doneData == 32'h1357_9BDF, "R8 data", doneData, 32'h1357_9BDF);
  endtask

  task automatic testDrAlign();
    putReq(1'b1, 32'h200, 32'h1, 1'b0);
    chk(dsiFault && !devValid, "R5 dr0", {31'b0, dsiFault}, 32'h1);
    putReq(1'b0, 32'h202, 32'h1, 1'b1);
    chk(alignFault && !dsiFault && !devValid, "R6 align", {31'b0, alignFault}, 32'h1);
    putReq(1'b0, 32'h201, 32'h1, 1'b0);
    chk(dsiFault && !alignFault, "R6 priority", {30'b0, dsiFault, alignFault}, 32'h2);
    @(negedge clk);
    chk(!devValid, "R6 nodev", {31'b0, devValid}, 32'h0);
  endtask

  task automatic testInval();
    @(negedge clk);
    invalPending = 1'b1;
    reqValid = 1'b1; reqStore = 1'b1; reqAddr = 32'h300; reqWdata = 32'h77; reqDr = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!reqReady && !devValid, "R10 stall", {31'b0, reqReady}, 32'h0);
    end
    invalPending = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    chk(devValid && devAddr == 32'h300, "R10 resume", devAddr, 32'h300);
    @(negedge clk);
    chk(doneValid, "R10 done", {31'b0, doneValid}, 32'h1);
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = 32'h0; cfgHyp = 1'b1;
    reqValid = 1'b1; reqStore = 1'b1; reqAddr = 32'h400; reqWdata = 32'h9; reqDr = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    chk(devValid && !dsiFault, "R11 old enable", {31'b0, devValid}, 32'h1);
    chk(cfgRdData == 32'h0, "R11 new value", cfgRdData, 32'h0);
    @(negedge clk);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = 32'h8000_0002;
    reqValid = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    chk(dsiFault && !devValid, "R11 old disable", {31'b0, dsiFault}, 32'h1);
    chk(cfgRdData == 32'h8000_0002, "R11 enabled", cfgRdData, 32'h8000_0002);
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rst = 1'b1; cfgWrEn = 1'b0; cfgWrData = '0; cfgHyp = 1'b1;
    reqValid = 1'b0; reqStore = 1'b0; reqAddr = '0; reqWdata = '0; reqDr = 1'b1;
    invalPending = 1'b0; devReady = 1'b1; devRspValid = 1'b0; devRspData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testDisabled();
    testPriv();
    testLayout();
    testStore(0);
    testStore(3);
    testLoad();
    testDrAlign();
    testInval();
    testSameCycle();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule